// File: doc/BRIEF.md
# Parallel Sampling-Converter Host Controller

This block sits in FPGA fabric beside an external 12-bit successive-approximation converter that has a parallel result bus. The controller starts conversions, either when a request input is held or on its own in free-running mode. It sends each conversion command as a bounded low strobe and releases both strobes before the converter can finish. It then watches the converter's conversion-done line through a synchronizer and fetches the result once that line rises. The fetch is either one 12-lane word read or two byte reads. In the byte form, the lanes for the second byte are swapped into place.

The result is a 12-bit two's-complement code. The controller widens it to 16 bits with sign extension and presents it on a valid/ready stream. It holds the word until the consumer accepts it. No conversion is launched while a word is still waiting on the stream. Commands are never spaced closer than a programmed minimum, so the converter's input stage has time to acquire. A conversion that never completes raises a timeout pulse and lets the controller recover.

Top module: `adc_par_host`

## Requirements
- R1: A conversion command holds `adc_sel_n_o` low and `adc_read_o` low together for exactly `PULSE_CYC` clock cycles. The default of 5 cycles at 100 MHz stays between 40 ns and 6 us.
- R2: Both `adc_sel_n_o` and `adc_read_o` are high in every cycle in which `adc_idle_i` rises after a conversion.
- R3: A read phase drives `adc_sel_n_o` low and `adc_read_o` high. It begins only after the rise of `adc_idle_i` has passed a two-flop synchronizer, and it never occurs while `adc_idle_i` is low.
- R4: The first cycles of two consecutive conversion commands are at least `SPACING_CYC` cycles apart. When a request is pending the whole time, they are exactly `SPACING_CYC` apart.
- R5: Word mode (`byte_mode_i`=0, sampled when a command is issued) uses a single read with `adc_lane_o` low. It captures all 12 lanes in the `ACCESS_CYC`-th cycle of that read.
- R6: Byte mode (`byte_mode_i`=1) uses two reads of `ACCESS_CYC` cycles each. The first read, with `adc_lane_o` low, takes lanes [11:4] as result bits [11:4]. The second read, with `adc_lane_o` high, takes lanes [11:8] as result bits [3:0].
- R7: `m_data_o` is the 12-bit result sign-extended to 16 bits, with bit 11 copied into bits 15:12.
- R8: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` stays high, `m_data_o` stays unchanged and no new conversion command is issued, even in free-running mode.
- R9: `start_i` has no effect outside the idle state. A request raised during a conversion adds no command.
- R10: With `free_run_i` high, commands are issued without `start_i`, one per accepted result, at the R4 spacing.
- R11: If `adc_idle_i` has not risen within `TIMEOUT_CYC` cycles of a command's first cycle, `timeout_o` pulses for one cycle, no result is presented, and the controller returns to idle.
- R12: After reset, `adc_sel_n_o`, `adc_read_o` are high, `adc_lane_o`, `m_valid_o`, `timeout_o` are low and `m_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, acted on in idle only |
| free_run_i | input | 1 | Launch conversions continuously at the minimum spacing |
| byte_mode_i | input | 1 | 1 selects two byte reads, 0 a single word read |
| adc_idle_i | input | 1 | Converter conversion-done line, low while converting |
| adc_data_i | input | 12 | Converter parallel data lanes |
| adc_sel_n_o | output | 1 | Converter select, active low |
| adc_read_o | output | 1 | High selects read, low (with select) commands a conversion |
| adc_lane_o | output | 1 | Byte lane select: 0 upper byte, 1 lower bits |
| m_valid_o | output | 1 | Result word valid |
| m_data_o | output | 16 | Sign-extended result |
| m_ready_i | input | 1 | Consumer accepts the result |
| timeout_o | output | 1 | One-cycle pulse on a conversion that never completed |

## Verification
The hardest situation to reach is a consumer that stalls while free-running mode wants another sample. R8 only means something if the spacing timer has already expired while the word is still pending. The bench therefore holds `m_ready_i` low for longer than `SPACING_CYC` with `free_run_i` high, and counts commands seen on the converter pins. The second hard case is a request raised during a conversion. The bench raises `start_i` while its converter model is mid-conversion and then counts commands. The converter model also drives garbage on the lanes until a read phase has been stable for several cycles, so capturing too early shows up as a wrong result.

// File: rtl/adc_par_pkg.sv
`timescale 1ns/1ps
package adc_par_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_WLOW  = 3'd2,
    ST_WHIGH = 3'd3,
    ST_RHI   = 3'd4,
    ST_RLO   = 3'd5,
    ST_OUT   = 3'd6
  } seq_state_e;
endpackage

// File: rtl/adc_level_sync.sv
`timescale 1ns/1ps
module adc_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_pace_timer.sv
`timescale 1ns/1ps
module adc_pace_timer #(
  parameter int SPACING_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic launch_i,
  output logic ok_o
);
  localparam int CW = $clog2(SPACING_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (launch_i)
      cnt_q <= CW'(SPACING_CYC - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q == '0);
endmodule

// File: rtl/adc_result_asm.sv
`timescale 1ns/1ps
module adc_result_asm #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_word_i,
  input  logic              cap_hi_i,
  input  logic              cap_lo_i,
  input  logic [DATA_W-1:0] lanes_i,
  output logic [OUT_W-1:0]  data_o
);
  localparam int REST_W = DATA_W - BYTE_W;
  localparam int EXT_W  = OUT_W - DATA_W;

  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst)
      res_q <= '0;
    else if (cap_word_i)
      res_q <= lanes_i;
    else if (cap_hi_i)
      res_q[DATA_W-1 -: BYTE_W] <= lanes_i[DATA_W-1 -: BYTE_W];
    else if (cap_lo_i)
      res_q[REST_W-1:0] <= lanes_i[DATA_W-1 -: REST_W];
  end

  assign data_o = {{EXT_W{res_q[DATA_W-1]}}, res_q};
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_par_pkg::*;
#(
  parameter int PULSE_CYC   = 5,
  parameter int ACCESS_CYC  = 10,
  parameter int TIMEOUT_CYC = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic free_run_i,
  input  logic byte_mode_i,
  input  logic pace_ok_i,
  input  logic idle_lvl_i,
  input  logic idle_rise_i,
  input  logic m_ready_i,
  output logic launch_o,
  output logic cap_word_o,
  output logic cap_hi_o,
  output logic cap_lo_o,
  output logic sel_n_o,
  output logic read_o,
  output logic lane_o,
  output logic valid_o,
  output logic timeout_o
);
  localparam int WMAX = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int TW   = $clog2(TIMEOUT_CYC + 1);

  seq_state_e     state_q, nxt;
  logic [WW-1:0]  wait_q;
  logic [TW-1:0]  tmo_q;
  logic           bytem_q;
  logic           tmo_hit;

  always_comb begin
    nxt        = state_q;
    launch_o   = 1'b0;
    cap_word_o = 1'b0;
    cap_hi_o   = 1'b0;
    cap_lo_o   = 1'b0;
    tmo_hit    = 1'b0;
    case (state_q)
      ST_IDLE:  if ((start_i || free_run_i) && pace_ok_i) begin
                  nxt = ST_PULSE;
                  launch_o = 1'b1;
                end
      ST_PULSE: if (wait_q == '0) nxt = ST_WLOW;
      ST_WLOW:  if (tmo_q == '0) begin
                  nxt = ST_IDLE;
                  tmo_hit = 1'b1;
                end else if (!idle_lvl_i) nxt = ST_WHIGH;
      ST_WHIGH: if (idle_rise_i) nxt = ST_RHI;
                else if (tmo_q == '0) begin
                  nxt = ST_IDLE;
                  tmo_hit = 1'b1;
                end
      ST_RHI:   if (wait_q == '0) begin
                  if (bytem_q) begin
                    cap_hi_o = 1'b1;
                    nxt = ST_RLO;
                  end else begin
                    cap_word_o = 1'b1;
                    nxt = ST_OUT;
                  end
                end
      ST_RLO:   if (wait_q == '0) begin
                  cap_lo_o = 1'b1;
                  nxt = ST_OUT;
                end
      ST_OUT:   if (m_ready_i) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wait_q    <= '0;
      tmo_q     <= '0;
      bytem_q   <= 1'b0;
      sel_n_o   <= 1'b1;
      read_o    <= 1'b1;
      lane_o    <= 1'b0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q <= nxt;
      if (launch_o) begin
        wait_q  <= WW'(PULSE_CYC - 1);
        tmo_q   <= TW'(TIMEOUT_CYC - 1);
        bytem_q <= byte_mode_i;
      end else begin
        if ((nxt == ST_RHI && state_q != ST_RHI) || (nxt == ST_RLO && state_q != ST_RLO))
          wait_q <= WW'(ACCESS_CYC - 1);
        else if (wait_q != '0)
          wait_q <= wait_q - 1'b1;
        if ((state_q == ST_PULSE || state_q == ST_WLOW || state_q == ST_WHIGH) && tmo_q != '0)
          tmo_q <= tmo_q - 1'b1;
      end
      sel_n_o   <= !(nxt == ST_PULSE || nxt == ST_RHI || nxt == ST_RLO);
      read_o    <= (nxt != ST_PULSE);
      lane_o    <= (nxt == ST_RLO);
      valid_o   <= (nxt == ST_OUT);
      timeout_o <= tmo_hit;
    end
  end
endmodule

// File: rtl/adc_par_host.sv
`timescale 1ns/1ps
module adc_par_host #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYC   = 5,
  parameter int ACCESS_CYC  = 10,
  parameter int SPACING_CYC = 1000,
  parameter int TIMEOUT_CYC = 1500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              free_run_i,
  input  logic              byte_mode_i,
  input  logic              adc_idle_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_sel_n_o,
  output logic              adc_read_o,
  output logic              adc_lane_o,
  output logic              m_valid_o,
  output logic [OUT_W-1:0]  m_data_o,
  input  logic              m_ready_i,
  output logic              timeout_o
);
  logic idle_lvl, idle_rise, pace_ok, launch;
  logic cap_word, cap_hi, cap_lo;

  adc_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(adc_idle_i),
    .level_o(idle_lvl), .rise_o(idle_rise)
  );

  adc_pace_timer #(.SPACING_CYC(SPACING_CYC)) u_pace (
    .clk(clk), .rst(rst), .launch_i(launch), .ok_o(pace_ok)
  );

  adc_seq_ctrl #(
    .PULSE_CYC(PULSE_CYC), .ACCESS_CYC(ACCESS_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .free_run_i(free_run_i),
    .byte_mode_i(byte_mode_i), .pace_ok_i(pace_ok), .idle_lvl_i(idle_lvl),
    .idle_rise_i(idle_rise), .m_ready_i(m_ready_i), .launch_o(launch),
    .cap_word_o(cap_word), .cap_hi_o(cap_hi), .cap_lo_o(cap_lo),
    .sel_n_o(adc_sel_n_o), .read_o(adc_read_o), .lane_o(adc_lane_o),
    .valid_o(m_valid_o), .timeout_o(timeout_o)
  );

  adc_result_asm #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .OUT_W(OUT_W)) u_asm (
    .clk(clk), .rst(rst), .cap_word_i(cap_word), .cap_hi_i(cap_hi),
    .cap_lo_i(cap_lo), .lanes_i(adc_data_i), .data_o(m_data_o)
  );
endmodule

// File: rtl/adc_par_host_chk.sv
`timescale 1ns/1ps
module adc_par_host_chk #(
  parameter int OUT_W       = 16,
  parameter int PULSE_CYC   = 5,
  parameter int SPACING_CYC = 1000
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_sel_n_o,
  input logic             adc_read_o,
  input logic             adc_lane_o,
  input logic             adc_idle_i,
  input logic             m_valid_o,
  input logic [OUT_W-1:0] m_data_o,
  input logic             m_ready_i,
  input logic             timeout_o
);
  logic        conv, conv_q, rd;
  logic [31:0] width_q, gap_q;

  assign conv = !adc_sel_n_o && !adc_read_o;
  assign rd   = !adc_sel_n_o && adc_read_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q  <= 1'b0;
      width_q <= '0;
      gap_q   <= 32'(SPACING_CYC);
    end else begin
      conv_q  <= conv;
      width_q <= conv ? width_q + 1 : '0;
      if (conv && !conv_q) gap_q <= 32'd1;
      else if (gap_q < 32'(SPACING_CYC)) gap_q <= gap_q + 1;
    end
  end

  assert_pulse_max_R1: assert property (@(posedge clk) disable iff (rst)
    conv |-> width_q < 32'(PULSE_CYC));
  assert_pulse_len_R1: assert property (@(posedge clk) disable iff (rst)
    (!conv && conv_q) |-> width_q == 32'(PULSE_CYC));
  assert_strobes_off_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_idle_i) |-> (adc_sel_n_o && adc_read_o));
  assert_read_idle_R3: assert property (@(posedge clk) disable iff (rst)
    rd |-> adc_idle_i);
  assert_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (conv && !conv_q) |-> gap_q >= 32'(SPACING_CYC));
  assert_lane_in_read_R6: assert property (@(posedge clk) disable iff (rst)
    adc_lane_o |-> rd);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));
  assert_no_cmd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    m_valid_o |-> !conv);
  assert_timeout_novalid_R11: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> !m_valid_o);
endmodule

bind adc_par_host adc_par_host_chk #(
  .OUT_W(OUT_W), .PULSE_CYC(PULSE_CYC), .SPACING_CYC(SPACING_CYC)
) u_chk (
  .clk(clk), .rst(rst), .adc_sel_n_o(adc_sel_n_o), .adc_read_o(adc_read_o),
  .adc_lane_o(adc_lane_o), .adc_idle_i(adc_idle_i), .m_valid_o(m_valid_o),
  .m_data_o(m_data_o), .m_ready_i(m_ready_i), .timeout_o(timeout_o)
);

// File: tb/sim_adc_par_host.sv
`timescale 1ns/1ps
module sim_adc_par_host;
  localparam int PULSE   = 5;
  localparam int ACCESS  = 10;
  localparam int SPACING = 1000;
  localparam int TMO     = 600;
  localparam int CONV_LAT = 300;
  localparam int MODEL_ACC = 7;
  localparam int LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, free_run = 1'b0, byte_mode = 1'b0, m_ready = 1'b0;
  logic idle_q = 1'b1;
  logic [11:0] lanes = 12'hA5A;
  logic sel_n, readm, lane, m_valid, tmo;
  logic [15:0] m_data;

  always #5 clk = ~clk;

  adc_par_host #(
    .PULSE_CYC(PULSE), .ACCESS_CYC(ACCESS), .SPACING_CYC(SPACING), .TIMEOUT_CYC(TMO)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start), .free_run_i(free_run),
    .byte_mode_i(byte_mode), .adc_idle_i(idle_q), .adc_data_i(lanes),
    .adc_sel_n_o(sel_n), .adc_read_o(readm), .adc_lane_o(lane),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_ready_i(m_ready), .timeout_o(tmo)
  );

  int checks = 0, errors = 0;
  int cyc = 0, starts = 0, last_start = -1, last_gap = 0, pw = 0, age = 0;
  int conv_left = 0, lo_reads = 0;
  bit respond = 1'b1, prev_conv = 1'b0, prev_rd = 1'b0, prev_lane = 1'b0, done = 1'b0;
  logic [11:0] next_sample = 12'h000, held = 12'h000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sext(input logic [11:0] v);
    return {{4{v[11]}}, v};
  endfunction

  // converter model, updated away from the active edge
  always @(negedge clk) begin
    bit conv, rd;
    cyc++;
    conv = !sel_n && !readm;
    rd   = !sel_n && readm;
    if (!rst) begin
      if (conv) pw++;
      if (conv && !prev_conv) begin
        starts++;
        if (last_start >= 0) begin
          last_gap = cyc - last_start;
          chk(last_gap >= SPACING, "R4 spacing", last_gap, SPACING);
        end
        last_start = cyc;
        if (idle_q && respond) begin
          idle_q = 1'b0;
          conv_left = CONV_LAT;
        end
      end
      if (!conv && prev_conv) begin
        chk(pw == PULSE, "R1 pulse width", pw, PULSE);
        pw = 0;
      end
      if (!idle_q) begin
        if (conv_left > 0) conv_left--;
        else begin
          chk(sel_n && readm, "R2 strobes high at done", {sel_n, readm}, 3);
          idle_q = 1'b1;
          held = next_sample;
        end
      end
      if (rd) begin
        if (!idle_q) chk(1'b0, "R3 read during conversion", 1, 0);
        if (prev_rd && lane == prev_lane) age++;
        else age = 0;
        if (lane) lo_reads++;
      end else age = 0;
      lanes = (rd && age >= MODEL_ACC) ?
              (lane ? {held[3:0], 4'b0000, held[11:8]} : held) : 12'hA5A;
      prev_conv = conv;
      prev_rd = rd;
      prev_lane = lane;
    end
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic wait_cmd;
    for (int i = 0; i < 3000; i++) begin
      if (!sel_n && !readm) break;
      tick();
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (m_valid) begin got = 1'b1; break; end
      tick();
    end
  endtask

  task automatic accept;
    m_ready = 1'b1;
    tick();
    m_ready = 1'b0;
  endtask

  task automatic run_one(input logic [11:0] v, input bit bm, input string req);
    bit got;
    int lo0;
    next_sample = v;
    byte_mode = bm;
    start = 1'b1;
    wait_cmd();
    start = 1'b0;
    lo0 = lo_reads;
    wait_valid(got);
    chk(got && m_data == sext(v), req, m_data, sext(v));
    if (bm) chk(lo_reads - lo0 == ACCESS, "R6 second lane read", lo_reads - lo0, ACCESS);
    else    chk(lo_reads == lo0, "R5 single read", lo_reads - lo0, 0);
    accept();
    chk(!m_valid, "R8 valid drops on accept", m_valid, 0);
  endtask

  task automatic test_reset;
    chk(sel_n && readm && !lane, "R12 strobes at reset", {sel_n, readm, lane}, 6);
    chk(!m_valid && !tmo && m_data == 16'h0, "R12 outputs at reset", m_data, 0);
  endtask

  task automatic test_word;
    run_one(12'h7FF, 1'b0, "R5 R7 word max positive");
    run_one(12'h800, 1'b0, "R5 R7 word most negative");
    run_one(12'hFFF, 1'b0, "R7 word minus one");
    run_one(12'h000, 1'b0, "R5 word zero");
  endtask

  task automatic test_byte;
    run_one(12'h5A3, 1'b1, "R6 byte pattern");
    run_one(12'h9C6, 1'b1, "R6 R7 byte negative");
    run_one(12'h00F, 1'b1, "R6 byte low nibble");
  endtask

  task automatic test_spacing;
    run_one(12'h123, 1'b0, "R4 first");
    run_one(12'h321, 1'b0, "R4 second");
    chk(last_gap == SPACING, "R4 exact spacing with held request", last_gap, SPACING);
  endtask

  task automatic test_hold;
    bit got;
    int s0;
    logic [15:0] d0;
    next_sample = 12'hABC;
    byte_mode = 1'b0;
    free_run = 1'b1;
    wait_valid(got);
    s0 = starts;
    d0 = m_data;
    for (int i = 0; i < SPACING + 200; i++) tick();
    chk(m_valid && m_data == d0, "R8 data held", m_data, d0);
    chk(starts == s0, "R8 no command while held", starts - s0, 0);
    free_run = 1'b0;
    accept();
  endtask

  task automatic test_ignore;
    bit got;
    int s0;
    s0 = starts;
    next_sample = 12'h456;
    start = 1'b1;
    wait_cmd();
    start = 1'b0;
    for (int i = 0; i < 40; i++) tick();
    start = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    start = 1'b0;
    wait_valid(got);
    chk(got && m_data == sext(12'h456), "R9 result", m_data, sext(12'h456));
    accept();
    for (int i = 0; i < SPACING + 50; i++) tick();
    chk(starts - s0 == 1, "R9 extra request ignored", starts - s0, 1);
  endtask

  task automatic test_free_run;
    bit got;
    int s0;
    logic [11:0] vals [3];
    vals[0] = 12'h801; vals[1] = 12'h7FE; vals[2] = 12'h2B4;
    s0 = starts;
    byte_mode = 1'b1;
    free_run = 1'b1;
    for (int k = 0; k < 3; k++) begin
      next_sample = vals[k];
      wait_valid(got);
      chk(got && m_data == sext(vals[k]), "R10 free-run result", m_data, sext(vals[k]));
      if (k == 2) free_run = 1'b0;
      accept();
    end
    for (int i = 0; i < SPACING + 50; i++) tick();
    chk(starts - s0 == 3, "R10 command count", starts - s0, 3);
    chk(last_gap == SPACING, "R10 R4 free-run spacing", last_gap, SPACING);
  endtask

  task automatic test_timeout;
    int t0, dt;
    bit seen, vseen;
    respond = 1'b0;
    start = 1'b1;
    wait_cmd();
    start = 1'b0;
    t0 = cyc;
    seen = 1'b0; vseen = 1'b0; dt = 0;
    for (int i = 0; i < 2 * TMO; i++) begin
      if (m_valid) vseen = 1'b1;
      if (tmo && !seen) begin seen = 1'b1; dt = cyc - t0; end
      tick();
    end
    chk(seen && dt >= TMO - 1 && dt <= TMO + 1, "R11 timeout delay", dt, TMO);
    chk(!vseen && sel_n && readm, "R11 no result, idle strobes", vseen, 0);
    respond = 1'b1;
    run_one(12'h3C3, 1'b0, "R11 recovery after timeout");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) tick();
    rst = 1'b0;
    tick();
    test_reset();
    test_word();
    test_byte();
    test_spacing();
    test_hold();
    test_ignore();
    test_free_run();
    test_timeout();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule